// File: doc/BRIEF.md
# Dual-Gain Pixel Merge Pipeline

This block takes every pixel as a pair of 11-bit samples taken from the same signal at the same time. One sample comes through a high-gain path and one through a low-gain path. For each pixel it keeps one sample: the high-gain sample is used while it stays below a programmable threshold, and the low-gain sample is used once the high-gain sample reaches that threshold. It then subtracts that path's per-pixel DC offset and multiplies by that path's per-pixel gain coefficient. The coefficient also absorbs the ratio between the two paths, which is roughly 25 to 27. The result is a linear 16-bit wide-range value, about 0.45 electrons per count.

A single-path mode turns off the threshold choice. It always takes either the high-gain or the low-gain sample and limits the result to 12 bits. Pixels move over a valid/ready stream through three registered stages (select, offset, multiply-and-saturate). A flag beside each output reports which path was used. A pixel counter addresses the calibration table. A start-of-frame flag on an input pixel resets the counter. Threshold, mode and calibration entries are loaded through a plain address/data/write-enable port.

Top module: `dg_merge`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: In merged mode (mode bit 0 = 0), the high-gain sample is used when it is below the threshold, and the low-gain sample when it is greater than or equal to it. `out_lo_o` is 1 exactly when the low-gain sample was used.
- R3: In single-path mode (mode register at address 1, bit 0 = 1), mode bit 1 alone selects the path (0 high, 1 low), whatever the threshold. The output never exceeds 4095.
- R4: The selected path's per-pixel offset (a signed 12-bit value in write data bits 11:0) is subtracted from the sample. A negative difference becomes 0.
- R5: The difference is multiplied by the selected path's per-pixel gain, an unsigned Q6.10 value (1024 = 1.0), and the product is truncated by shifting right 10 bits.
- R6: A scaled value above the output range becomes 65535 in merged mode and 4095 in single-path mode.
- R7: The calibration index is 0 for a pixel flagged start-of-frame. Otherwise it is one more than the index of the previously accepted pixel, and it wraps from NPIX-1 to 0.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the output data and flag hold. Pixels leave in the order they were accepted, and none is lost or repeated. `in_ready_o` drops only when all three stages are full and stalled.
- R9: With `out_ready_i` held at 1, a pixel accepted at a clock edge is presented on the output after the second following edge.
- R10: A calibration write is ignored while any stage holds a pixel. The calibration map is: address bit 8 = 1 selects the table, bit 7 the path (0 high, 1 low), bit 6 the field (0 offset, 1 gain), and bits 5:0 the pixel index.
- R11: Reset sets the threshold (address 0) to 2047, the mode to merged, all offsets to 0 and all gains to 1.0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 9 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_sof_i | input | 1 | Input pixel is first of a frame |
| in_hi_i | input | 11 | High-gain sample |
| in_lo_i | input | 11 | Low-gain sample |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream can take the output pixel |
| out_data_o | output | 16 | Corrected pixel value |
| out_lo_o | output | 1 | Output pixel came from the low-gain path |

## Verification
The hardest case to reach is a calibration write that arrives while pixels sit inside the pipeline. Only a stall that fills all three stages keeps the pipeline busy long enough for a write to land on a known pixel. The bench holds `out_ready_i` low and pushes exactly three pixels. It then writes the offset of index 0 while the pipeline is frozen. After the stall is released, it sends a start-of-frame pixel whose result reveals whether the old offset survived. Counter wrap needs a full table of distinct offsets, so that every index leaves its own mark on the output.

// File: rtl/dg_pkg.sv
package dg_pkg;
  localparam int REG_THR  = 0;
  localparam int REG_MODE = 1;
  localparam int MODE_SINGLE_BIT = 0;
  localparam int MODE_LOPATH_BIT = 1;
  typedef enum logic {FIELD_OFF = 1'b0, FIELD_GAIN = 1'b1} cal_field_e;
endpackage

// File: rtl/dg_regs.sv
module dg_regs
  import dg_pkg::*;
#(
  parameter int NPIX = 64,
  parameter int IW   = 6,
  parameter int SW   = 11,
  parameter int OW   = 12,
  parameter int GW   = 16,
  parameter int FRAC = 10,
  parameter int AW   = IW + 3,
  parameter int CW   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [CW-1:0]        wdata_i,
  input  logic                 idle_i,
  input  logic                 path_i,
  input  logic [IW-1:0]        idx_i,
  output logic signed [OW-1:0] off_o,
  output logic [GW-1:0]        gain_o,
  output logic [SW-1:0]        thr_o,
  output logic                 single_o,
  output logic                 single_lo_o,
  output logic                 cal_wr_o
);
  localparam logic [GW-1:0] GAIN_ONE = GW'(1) << FRAC;

  logic signed [OW-1:0] off_q  [2][NPIX];
  logic [GW-1:0]        gain_q [2][NPIX];
  logic                 w_path;
  cal_field_e           w_field;
  logic [IW-1:0]        w_idx;
  logic                 reg_wr;

  assign w_path   = addr_i[AW-2];
  assign w_field  = cal_field_e'(addr_i[AW-3]);
  assign w_idx    = addr_i[IW-1:0];
  assign cal_wr_o = we_i & addr_i[AW-1] & idle_i & (int'(w_idx) < NPIX);
  assign reg_wr   = we_i & ~addr_i[AW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o       <= '1;
      single_o    <= 1'b0;
      single_lo_o <= 1'b0;
    end else if (reg_wr) begin
      if (addr_i[AW-2:0] == (AW-1)'(REG_THR)) thr_o <= wdata_i[SW-1:0];
      if (addr_i[AW-2:0] == (AW-1)'(REG_MODE)) begin
        single_o    <= wdata_i[MODE_SINGLE_BIT];
        single_lo_o <= wdata_i[MODE_LOPATH_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < NPIX; i++) begin
          off_q[p][i]  <= '0;
          gain_q[p][i] <= GAIN_ONE;
        end
      end
    end else if (cal_wr_o) begin
      if (w_field == FIELD_OFF) off_q[w_path][w_idx] <= wdata_i[OW-1:0];
      else                      gain_q[w_path][w_idx] <= wdata_i[GW-1:0];
    end
  end

  assign off_o  = off_q[path_i][idx_i];
  assign gain_o = gain_q[path_i][idx_i];
endmodule

// File: rtl/dg_pixcnt.sv
module dg_pixcnt #(
  parameter int NPIX = 64,
  parameter int IW   = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          sof_i,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(NPIX - 1);
  logic [IW-1:0] cnt_q;

  assign idx_o = sof_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (acc_i) cnt_q <= (idx_o == LAST) ? '0 : idx_o + IW'(1);
  end
endmodule

// File: rtl/dg_scale.sv
module dg_scale #(
  parameter int DW   = 12,
  parameter int GW   = 16,
  parameter int FRAC = 10,
  parameter int OUTW = 16,
  parameter int NW   = 12
) (
  input  logic [DW-1:0]   diff_i,
  input  logic [GW-1:0]   gain_i,
  input  logic            single_i,
  output logic [OUTW-1:0] data_o
);
  localparam int PW = DW + GW;
  localparam logic [PW-1:0]   LIM_WIDE = PW'((64'd1 << OUTW) - 1);
  localparam logic [PW-1:0]   LIM_NAR  = PW'((64'd1 << NW) - 1);
  localparam logic [OUTW-1:0] SAT_NAR  = OUTW'((64'd1 << NW) - 1);

  logic [PW-1:0] prod;
  logic [PW-1:0] scaled;
  logic [PW-1:0] lim;

  assign prod   = PW'(diff_i) * PW'(gain_i);
  assign scaled = prod >> FRAC;
  assign lim    = single_i ? LIM_NAR : LIM_WIDE;

  always_comb begin
    if (scaled > lim) data_o = single_i ? SAT_NAR : '1;
    else              data_o = scaled[OUTW-1:0];
  end
endmodule

// File: rtl/dg_merge.sv
module dg_merge #(
  parameter int NPIX = 64,
  parameter int SW   = 11,
  parameter int OW   = 12,
  parameter int GW   = 16,
  parameter int FRAC = 10,
  parameter int OUTW = 16,
  parameter int NW   = 12,
  parameter int CW   = 16,
  parameter int IW   = $clog2(NPIX),
  parameter int AW   = IW + 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [CW-1:0]   cfg_wdata_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic            in_sof_i,
  input  logic [SW-1:0]   in_hi_i,
  input  logic [SW-1:0]   in_lo_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [OUTW-1:0] out_data_o,
  output logic            out_lo_o
);
  localparam int DW = OW;

  logic en1, en2, en3, acc;
  logic v1, v2, v3;
  logic idle, cal_wr;

  logic [SW-1:0] thr;
  logic          single, single_lo;
  logic [IW-1:0] cur_idx;
  logic          sel_lo;

  logic [SW-1:0] s1_sample;
  logic          s1_lo, s1_single;
  logic [IW-1:0] s1_idx;

  logic signed [OW-1:0] off;
  logic [GW-1:0]        gain;
  logic signed [DW:0]   diff_w;
  logic [DW-1:0]        diff_c;

  logic [DW-1:0]   s2_diff;
  logic [GW-1:0]   s2_gain;
  logic            s2_lo, s2_single;

  logic [OUTW-1:0] scaled;
  logic [OUTW-1:0] s3_data;
  logic            s3_lo, s3_single;

  assign en3        = ~v3 | out_ready_i;
  assign en2        = ~v2 | en3;
  assign en1        = ~v1 | en2;
  assign in_ready_o = en1;
  assign acc        = in_valid_i & en1;
  assign idle       = ~v1 & ~v2 & ~v3;

  dg_regs #(
    .NPIX(NPIX), .IW(IW), .SW(SW), .OW(OW), .GW(GW), .FRAC(FRAC), .AW(AW), .CW(CW)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .idle_i(idle), .path_i(s1_lo), .idx_i(s1_idx),
    .off_o(off), .gain_o(gain), .thr_o(thr),
    .single_o(single), .single_lo_o(single_lo), .cal_wr_o(cal_wr)
  );

  dg_pixcnt #(.NPIX(NPIX), .IW(IW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .sof_i(in_sof_i), .idx_o(cur_idx)
  );

  // stage 1: path choice
  assign sel_lo = single ? single_lo : (in_hi_i >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; s1_sample <= '0; s1_lo <= 1'b0; s1_single <= 1'b0; s1_idx <= '0;
    end else if (en1) begin
      v1 <= in_valid_i;
      if (in_valid_i) begin
        s1_sample <= sel_lo ? in_lo_i : in_hi_i;
        s1_lo     <= sel_lo;
        s1_single <= single;
        s1_idx    <= cur_idx;
      end
    end
  end

  // stage 2: offset removal, clamp at zero
  assign diff_w = $signed({1'b0, DW'(s1_sample)}) - $signed({off[OW-1], off});
  assign diff_c = diff_w[DW] ? '0 : diff_w[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2 <= 1'b0; s2_diff <= '0; s2_gain <= '0; s2_lo <= 1'b0; s2_single <= 1'b0;
    end else if (en2) begin
      v2 <= v1;
      if (v1) begin
        s2_diff   <= diff_c;
        s2_gain   <= gain;
        s2_lo     <= s1_lo;
        s2_single <= s1_single;
      end
    end
  end

  // stage 3: gain and saturation
  dg_scale #(.DW(DW), .GW(GW), .FRAC(FRAC), .OUTW(OUTW), .NW(NW)) u_scale (
    .diff_i(s2_diff), .gain_i(s2_gain), .single_i(s2_single), .data_o(scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v3 <= 1'b0; s3_data <= '0; s3_lo <= 1'b0; s3_single <= 1'b0;
    end else if (en3) begin
      v3 <= v2;
      if (v2) begin
        s3_data   <= scaled;
        s3_lo     <= s2_lo;
        s3_single <= s2_single;
      end
    end
  end

  assign out_valid_o = v3;
  assign out_data_o  = s3_data;
  assign out_lo_o    = s3_lo;
endmodule

// File: rtl/dg_merge_chk.sv
module dg_merge_chk #(
  parameter int OUTW = 16,
  parameter int NW   = 12,
  parameter int IW   = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic            in_sof_i,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [OUTW-1:0] out_data_o,
  input logic            out_lo_o,
  input logic            single_i,
  input logic            cal_wr_i,
  input logic [IW-1:0]   idx_i
);
  localparam logic [OUTW-1:0] NAR_MAX = OUTW'((64'd1 << NW) - 1);

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_lo_o)); // R8

  AST_STALL_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> out_valid_o && !out_ready_i); // R8

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_valid_i && in_ready_o, 3) && $past(out_ready_i, 1) && $past(out_ready_i, 2)
    |-> out_valid_o); // R9

  AST_NARROW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && single_i |-> out_data_o <= NAR_MAX); // R3

  AST_CAL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_wr_i |-> !out_valid_o); // R10

  AST_SOF_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && in_sof_i |=> idx_i == '0); // R7
endmodule

bind dg_merge dg_merge_chk #(.OUTW(OUTW), .NW(NW), .IW(IW)) i_dg_merge_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_sof_i(in_sof_i),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .out_lo_o(out_lo_o),
  .single_i(s3_single), .cal_wr_i(cal_wr), .idx_i(s1_idx)
);

// File: tb/test_dg_merge.sv
module test_dg_merge;
  localparam int NPIX = 64;
  localparam int AW   = 9;
  localparam int QD   = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sof = 1'b0;
  logic [10:0] in_hi = '0;
  logic [10:0] in_lo = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        out_lo;

  dg_merge i_dg_merge (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_sof_i(in_sof),
    .in_hi_i(in_hi), .in_lo_i(in_lo),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_lo_o(out_lo)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  int thr_m = 2047;
  int single_m = 0, lopath_m = 0;
  int off_m  [2][NPIX];
  int gain_m [2][NPIX];
  int cnt_m = 0;

  int    exp_d [QD];
  int    exp_l [QD];
  string exp_t [QD];
  int    wr_p = 0, rd_p = 0;

  int or_mode = 0;  // 0 ready, 1 pattern, 2 stalled
  int cyc = 0;
  bit prev_stall = 1'b0;
  logic [15:0] prev_data;
  logic        prev_lo;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (or_mode)
      1:       out_ready = (cyc % 3) != 0;
      2:       out_ready = 1'b0;
      default: out_ready = 1'b1;
    endcase
    #5;
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid && out_data == prev_data && out_lo == prev_lo, "R8 hold",
              int'(out_data), int'(prev_data));
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_lo    = out_lo;
      if (out_valid && out_ready) begin
        if (rd_p == wr_p) check(1'b0, "R8 extra output", int'(out_data), -1);
        else begin
          check(int'(out_data) == exp_d[rd_p % QD], exp_t[rd_p % QD],
                int'(out_data), exp_d[rd_p % QD]);
          check(int'(out_lo) == exp_l[rd_p % QD], {exp_t[rd_p % QD], " path flag"},
                int'(out_lo), exp_l[rd_p % QD]);
          rd_p++;
        end
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 2000 && rd_p != wr_p; i++) @(negedge clk);
    check(rd_p == wr_p, "R8 drain", rd_p, wr_p);
    @(negedge clk);
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 9'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_thr(input int t);
    cfg_write(0, t); thr_m = t;
  endtask

  task automatic set_mode(input int single, input int lopath);
    cfg_write(1, (lopath << 1) | single); single_m = single; lopath_m = lopath;
  endtask

  task automatic wcal(input int path, input int field, input int idx, input int data,
                      input bit taken);
    cfg_write((1 << 8) | (path << 7) | (field << 6) | idx, data);
    if (taken) begin
      if (field == 0) off_m[path][idx] = ((data & 12'hFFF) ^ 12'h800) - 12'h800;
      else            gain_m[path][idx] = data & 16'hFFFF;
    end
  endtask

  task automatic send(input int hi, input int lo, input bit sof, input string tag);
    int idx, sel, s, d, p;
    bit acc;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = sof; in_hi = 11'(hi); in_lo = 11'(lo);
      #1;
      acc = in_ready;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    idx = sof ? 0 : cnt_m;
    cnt_m = (idx == NPIX - 1) ? 0 : idx + 1;
    sel = single_m ? lopath_m : (hi >= thr_m ? 1 : 0);
    s = sel ? lo : hi;
    d = s - off_m[sel][idx];
    if (d < 0) d = 0;
    p = (d * gain_m[sel][idx]) >>> 10;
    if (single_m && p > 4095) p = 4095;
    if (!single_m && p > 65535) p = 65535;
    exp_d[wr_p % QD] = p; exp_l[wr_p % QD] = sel; exp_t[wr_p % QD] = tag;
    wr_p++;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_defaults();
    send(100, 9, 1'b1, "R11 default below thr");
    send(2047, 37, 1'b0, "R11 default thr 2047");
    send(2046, 37, 1'b0, "R11 default gain one");
    drain();
  endtask

  task automatic t_thresh();
    set_thr(500);
    wcal(1, 1, 0, 26 * 1024, 1'b1);
    wcal(1, 1, 1, 26 * 1024, 1'b1);
    send(499, 10, 1'b1, "R2 just below threshold");
    send(500, 10, 1'b0, "R2 at threshold");
    send(1800, 70, 1'b0, "R2 above threshold");
    drain();
  endtask

  task automatic t_offset();
    wcal(0, 0, 0, 200, 1'b1);
    wcal(1, 0, 1, 16'hFFCE, 1'b1);
    wcal(0, 0, 2, 40, 1'b1);
    send(150, 3, 1'b1, "R4 clamp to zero");
    send(900, 10, 1'b0, "R4 negative offset low path");
    send(300, 3, 1'b0, "R4 positive offset high path");
    drain();
  endtask

  task automatic t_gain();
    wcal(0, 1, 0, 1536, 1'b1);
    wcal(0, 0, 0, 0, 1'b1);
    wcal(0, 1, 1, 100, 1'b1);
    send(101, 0, 1'b1, "R5 gain 1.5 truncation");
    send(301, 0, 1'b0, "R5 gain below one");
    drain();
  endtask

  task automatic t_sat();
    wcal(1, 1, 0, 16'hFFFF, 1'b1);
    wcal(1, 0, 0, 0, 1'b1);
    send(2047, 2047, 1'b1, "R6 merged saturate 65535");
    drain();
    set_mode(1, 0);
    wcal(0, 1, 0, 4096, 1'b1);
    send(2047, 5, 1'b1, "R6 narrow saturate 4095");
    send(1023, 5, 1'b1, "R6 narrow exact 4092");
    drain();
  endtask

  task automatic t_single();
    set_mode(1, 0);
    wcal(0, 1, 0, 1024, 1'b1);
    send(2000, 9, 1'b1, "R3 single high ignores thr");
    drain();
    set_mode(1, 1);
    wcal(1, 1, 0, 1024, 1'b1);
    send(3, 1500, 1'b1, "R3 single low path");
    drain();
    set_mode(0, 0);
  endtask

  task automatic t_counter();
    set_thr(2047);
    for (int i = 0; i < NPIX; i++) begin
      wcal(0, 0, i, i, 1'b1);
      wcal(0, 1, i, 1024, 1'b1);
    end
    send(1000, 0, 1'b1, "R7 sof index zero");
    for (int i = 1; i < NPIX + 6; i++) send(1000, 0, 1'b0, "R7 index sequence and wrap");
    send(1000, 0, 1'b1, "R7 sof restart");
    send(1000, 0, 1'b0, "R7 after restart");
    drain();
  endtask

  task automatic t_backpressure();
    or_mode = 1;
    send(10, 0, 1'b1, "R8 order under stall");
    for (int i = 1; i < 30; i++) send(10 + 13 * i, 0, 1'b0, "R8 order under stall");
    drain();
    or_mode = 0;
    @(negedge clk);
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_hi = 11'd321; in_lo = 11'd0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    cnt_m = 1;
    exp_d[wr_p % QD] = 321; exp_l[wr_p % QD] = 0; exp_t[wr_p % QD] = "R9 latency data";
    wr_p++;
    check(out_valid == 1'b0, "R9 not valid one edge after accept", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 not valid two edges after accept", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R9 valid after third stage", int'(out_valid), 1);
    drain();
  endtask

  task automatic t_calbusy();
    or_mode = 2;
    send(700, 0, 1'b1, "R10 stalled pixel");
    send(701, 0, 1'b0, "R10 stalled pixel");
    send(702, 0, 1'b0, "R10 stalled pixel");
    @(negedge clk);
    check(in_ready == 1'b0, "R8 full pipeline stalls input", int'(in_ready), 0);
    wcal(0, 0, 0, 77, 1'b0);
    or_mode = 0;
    drain();
    send(500, 0, 1'b1, "R10 busy write ignored");
    drain();
  endtask

  initial begin
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < NPIX; i++) begin
        off_m[p][i] = 0; gain_m[p][i] = 1024;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_defaults();
    t_thresh();
    t_offset();
    t_gain();
    t_sat();
    t_single();
    t_counter();
    t_backpressure();
    t_latency();
    t_calbusy();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", rd_p, wr_p);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule